// File: doc/BRIEF.md
# Reference Selection and Mode Controller

This block steers a clock-synchronizer loop. It watches a set of reference inputs (three by default), each reported as qualified or not by monitors outside the block, chooses which one the loop follows, and walks the loop's operating mode through free-run, lock acquisition, normal (locked) and holdover. The phase detector, loop filter and oscillator live elsewhere. The block only receives a lock-achieved level from them and returns the chosen reference index and the mode.

In automatic operation, each reference carries a 4-bit priority and a revertive-enable bit. A reference that has lost and then regained qualification must wait a programmable number of 1 ms ticks before it counts as available again. The mode machine enters holdover only when the followed reference fails and no other reference is available. A manual control overrides both the mode and the reference. Software gets level indicators for locked and holdover, plus a one-cycle pulse on every mode change that can drive an interrupt.

Top module: `refsel_mode_ctrl`

## Requirements
- R1: After reset the mode is free-run (mode code 0; codes are 0 free-run, 1 acquisition, 2 normal, 3 holdover), the selected reference is 0, and lock, holdover and the change pulse are all low. Reset release passes through a two-flop synchronizer, so the first functional edge is the third rising edge after `rst_n` rises.
- R2: In automatic mode, from free-run, the block moves to acquisition on the best available reference on the edge after any reference becomes available.
- R3: In automatic mode, from acquisition, the block moves to normal on an edge where `lock_i` is high, as long as the followed reference is still available and no revertive switch applies.
- R4: In acquisition or normal, if the followed reference is not available and another one is, the block selects the best available reference and enters acquisition.
- R5: In acquisition or normal, if no reference is available, the mode becomes holdover if normal was ever reached since reset, and free-run otherwise.
- R6: From holdover, once any reference is available, the block enters acquisition on the best available reference.
- R7: The best reference is the available one with the lowest 4-bit priority value. The priority of reference i sits in `pri_i[4i+3:4i]`. On equal values the lower index wins.
- R8: In acquisition or normal, while the followed reference remains available, the block switches to a better available reference (and enters acquisition) only if that reference's bit in `rev_en_i` is 1. Otherwise the selection is unchanged.
- R9: After its qualified flag has been low on any edge, a reference becomes available only once `tick_i` has been high on `wtr_i` edges with the flag high. If `wtr_i` is 0, it is available as soon as the flag is high.
- R10: While `man_en_i` is high, the next mode is `man_mode_i` and the next selection is `man_ref_i`. A `man_ref_i` value of 3 or more leaves the selection unchanged. `lock_i` has no effect in this mode.
- R11: `lock_o` is high exactly in normal mode, and `hold_o` is high exactly in holdover.
- R12: `mode_evt_o` is high for the single cycle in which a new mode value first appears on `mode_o`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual_i | input | NREF | Per-reference qualified flags |
| lock_i | input | 1 | Loop reports phase lock achieved |
| tick_i | input | 1 | 1 ms time-base pulse for wait-to-restore |
| man_en_i | input | 1 | 1 = manual control of mode and reference |
| man_mode_i | input | 2 | Forced mode code in manual control |
| man_ref_i | input | IDX_W | Forced reference index in manual control |
| pri_i | input | NREF*PRI_W | Packed per-reference priorities, lower value is stronger |
| rev_en_i | input | NREF | Per-reference revertive enable |
| wtr_i | input | WTR_W | Wait-to-restore time in ticks |
| sel_ref_o | output | IDX_W | Reference the loop follows |
| mode_o | output | 2 | Current mode code |
| lock_o | output | 1 | Locked indicator |
| hold_o | output | 1 | Holdover indicator |
| mode_evt_o | output | 1 | One-cycle pulse on a mode change |

## Verification
A corrupted mode or selection register shows on `mode_o`, `sel_ref_o` and the indicators on the very edge it is written, because all of them come straight from registers. A wrong wait-to-restore count stays hidden until the affected reference is needed. It then shows as a transition out of holdover or free-run that comes a tick too early or too late. A lost "ever locked" memory only surfaces when acquisition fails without an alternative, as free-run in place of holdover. The bench therefore compares every port to a cycle model on every clock and drives those rarer paths directly.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_NORM = 2'd2,
    MODE_HOLD = 2'd3
  } mode_e;
endpackage

// File: rtl/refsel_wtr.sv
// Wait-to-restore gate for one reference.
module refsel_wtr #(
  parameter int WTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_i,
  input  logic             tick_i,
  input  logic [WTR_W-1:0] wtr_i,
  output logic             avail_o
);
  logic [WTR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!qual_i) begin
      cnt_en = 1'b1;
      cnt_d  = wtr_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign avail_o = qual_i && (cnt_q == '0);
endmodule

// File: rtl/refsel_pick.sv
// Picks the strongest available reference: lowest priority value, lower index on ties.
module refsel_pick #(
  parameter int NREF  = 3,
  parameter int PRI_W = 4,
  parameter int IDX_W = 2
) (
  input  logic [NREF-1:0]       avail_i,
  input  logic [NREF*PRI_W-1:0] pri_i,
  output logic [IDX_W-1:0]      best_o,
  output logic                  any_o
);
  logic [PRI_W-1:0] best_pri;

  always_comb begin
    any_o    = 1'b0;
    best_o   = '0;
    best_pri = '1;
    for (int i = 0; i < NREF; i++) begin
      if (avail_i[i] && (!any_o || (pri_i[i*PRI_W +: PRI_W] < best_pri))) begin
        any_o    = 1'b1;
        best_o   = IDX_W'(i);
        best_pri = pri_i[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/refsel_fsm.sv
// Mode machine and selected-reference register.
module refsel_fsm
  import refsel_pkg::*;
#(
  parameter int NREF  = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  avail_i,
  input  logic [IDX_W-1:0] best_i,
  input  logic             any_i,
  input  logic             lock_i,
  input  logic [NREF-1:0]  rev_en_i,
  input  logic             man_en_i,
  input  logic [1:0]       man_mode_i,
  input  logic [IDX_W-1:0] man_ref_i,
  output mode_e            mode_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             evt_o
);
  localparam logic [IDX_W:0] NREF_L = (IDX_W+1)'(NREF);

  mode_e            mode_q, mode_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             synced_q, synced_d;
  logic             evt_q, evt_d;
  logic             cur_ok;

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    cur_ok = avail_i[sel_q];
    if (man_en_i) begin
      mode_d = mode_e'(man_mode_i);
      if ({1'b0, man_ref_i} < NREF_L) sel_d = man_ref_i;
    end else begin
      unique case (mode_q)
        MODE_FREE, MODE_HOLD: begin
          if (any_i) begin
            mode_d = MODE_ACQ;
            sel_d  = best_i;
          end
        end
        default: begin
          if (!cur_ok) begin
            if (any_i) begin
              mode_d = MODE_ACQ;
              sel_d  = best_i;
            end else begin
              mode_d = synced_q ? MODE_HOLD : MODE_FREE;
            end
          end else if ((best_i != sel_q) && rev_en_i[best_i]) begin
            mode_d = MODE_ACQ;
            sel_d  = best_i;
          end else if ((mode_q == MODE_ACQ) && lock_i) begin
            mode_d = MODE_NORM;
          end
        end
      endcase
    end
    synced_d = synced_q || (mode_d == MODE_NORM);
    evt_d    = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FREE;
      sel_q    <= '0;
      synced_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      sel_q    <= sel_d;
      synced_q <= synced_d;
      evt_q    <= evt_d;
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/refsel_mode_ctrl.sv
module refsel_mode_ctrl
  import refsel_pkg::*;
#(
  parameter int NREF  = 3,
  parameter int PRI_W = 4,
  parameter int WTR_W = 8,
  parameter int IDX_W = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREF-1:0]       qual_i,
  input  logic                  lock_i,
  input  logic                  tick_i,
  input  logic                  man_en_i,
  input  logic [1:0]            man_mode_i,
  input  logic [IDX_W-1:0]      man_ref_i,
  input  logic [NREF*PRI_W-1:0] pri_i,
  input  logic [NREF-1:0]       rev_en_i,
  input  logic [WTR_W-1:0]      wtr_i,
  output logic [IDX_W-1:0]      sel_ref_o,
  output logic [1:0]            mode_o,
  output logic                  lock_o,
  output logic                  hold_o,
  output logic                  mode_evt_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ok;
  logic [NREF-1:0]  avail;
  logic [IDX_W-1:0] best;
  logic             any_avail;
  mode_e            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  for (genvar g = 0; g < NREF; g++) begin : g_wtr
    refsel_wtr #(.WTR_W(WTR_W)) u_wtr (
      .clk    (clk),
      .rst_n  (rst_ok),
      .qual_i (qual_i[g]),
      .tick_i (tick_i),
      .wtr_i  (wtr_i),
      .avail_o(avail[g])
    );
  end

  refsel_pick #(.NREF(NREF), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_pick (
    .avail_i(avail),
    .pri_i  (pri_i),
    .best_o (best),
    .any_o  (any_avail)
  );

  refsel_fsm #(.NREF(NREF), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ok),
    .avail_i   (avail),
    .best_i    (best),
    .any_i     (any_avail),
    .lock_i    (lock_i),
    .rev_en_i  (rev_en_i),
    .man_en_i  (man_en_i),
    .man_mode_i(man_mode_i),
    .man_ref_i (man_ref_i),
    .mode_o    (mode),
    .sel_o     (sel_ref_o),
    .evt_o     (mode_evt_o)
  );

  assign mode_o = mode;
  assign lock_o = (mode == MODE_NORM);
  assign hold_o = (mode == MODE_HOLD);
endmodule

// File: rtl/refsel_mode_ctrl_chk.sv
module refsel_mode_ctrl_chk #(
  parameter int NREF  = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             man_en_i,
  input logic             lock_i,
  input logic [1:0]       mode_o,
  input logic [IDX_W-1:0] sel_ref_o,
  input logic             mode_evt_o
);
  // R12: a pulse only when the mode really changed
  p_evt_change_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_evt_o |-> (mode_o != $past(mode_o)));
  // R12: no pulse means no change
  p_evt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_evt_o |-> $stable(mode_o));
  // R2: free-run can only go to acquisition automatically
  p_free_exit_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (!man_en_i && mode_o == 2'd0) |=> (mode_o == 2'd0 || mode_o == 2'd1));
  // R6: holdover can only go to acquisition automatically
  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!man_en_i && mode_o == 2'd3) |=> (mode_o == 2'd3 || mode_o == 2'd1));
  // R3: automatic entry into normal needs acquisition plus lock
  p_norm_entry_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!man_en_i && mode_o != 2'd2 && !(mode_o == 2'd1 && lock_i)) |=> (mode_o != 2'd2));
  // R7: selection always names an existing reference
  p_sel_range_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    32'(sel_ref_o) < NREF);
endmodule

bind refsel_mode_ctrl refsel_mode_ctrl_chk #(.NREF(NREF), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .man_en_i  (man_en_i),
  .lock_i    (lock_i),
  .mode_o    (mode_o),
  .sel_ref_o (sel_ref_o),
  .mode_evt_o(mode_evt_o)
);

// File: tb/refsel_mode_ctrl_bench.sv
`timescale 1ns/1ps
module refsel_mode_ctrl_bench;
  localparam int NREF = 3, PRI_W = 4, WTR_W = 8, IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREF-1:0] qual_i;
  logic lock_i, tick_i, man_en_i;
  logic [1:0] man_mode_i;
  logic [IDX_W-1:0] man_ref_i;
  logic [NREF*PRI_W-1:0] pri_i;
  logic [NREF-1:0] rev_en_i;
  logic [WTR_W-1:0] wtr_i;
  logic [IDX_W-1:0] sel_ref_o;
  logic [1:0] mode_o;
  logic lock_o, hold_o, mode_evt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  int m_mode, m_sel, m_cnt[NREF], n_mode, n_sel;
  bit m_syn, m_evt, n_syn;

  always #2 clk = ~clk;

  refsel_mode_ctrl u_refsel_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .qual_i(qual_i), .lock_i(lock_i), .tick_i(tick_i),
    .man_en_i(man_en_i), .man_mode_i(man_mode_i), .man_ref_i(man_ref_i),
    .pri_i(pri_i), .rev_en_i(rev_en_i), .wtr_i(wtr_i),
    .sel_ref_o(sel_ref_o), .mode_o(mode_o), .lock_o(lock_o), .hold_o(hold_o),
    .mode_evt_o(mode_evt_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit av(int i);
    return qual_i[i] && (m_cnt[i] == 0);
  endfunction

  function automatic int prio(int i);
    return int'(pri_i[i*PRI_W +: PRI_W]);
  endfunction

  // R7 ordering
  function automatic int best_ref(output bit any);
    int b = 0;
    any = 0;
    for (int i = 0; i < NREF; i++)
      if (av(i) && (!any || prio(i) < prio(b))) begin any = 1; b = i; end
    return b;
  endfunction

  task automatic model_next();
    bit any;
    int b = best_ref(any);
    n_mode = m_mode; n_sel = m_sel;
    if (man_en_i) begin
      n_mode = int'(man_mode_i);
      if (int'(man_ref_i) < NREF) n_sel = int'(man_ref_i);
    end else if (m_mode == 0 || m_mode == 3) begin
      if (any) begin n_mode = 1; n_sel = b; end
    end else if (!av(m_sel)) begin
      if (any) begin n_mode = 1; n_sel = b; end
      else n_mode = m_syn ? 3 : 0;
    end else if (b != m_sel && rev_en_i[b]) begin
      n_mode = 1; n_sel = b;
    end else if (m_mode == 1 && lock_i) n_mode = 2;
    n_syn = m_syn || (n_mode == 2);
  endtask

  task automatic model_commit();
    m_evt = (n_mode != m_mode);
    m_mode = n_mode; m_sel = n_sel; m_syn = n_syn;
    for (int i = 0; i < NREF; i++) begin
      if (!qual_i[i]) m_cnt[i] = int'(wtr_i);
      else if (tick_i && m_cnt[i] != 0) m_cnt[i]--;
    end
  endtask

  task automatic cmp_model();
    chk(int'(mode_o) == m_mode, "R2-6 model mode", mode_o, m_mode);
    chk(int'(sel_ref_o) == m_sel, "R7 model sel", sel_ref_o, m_sel);
    chk(lock_o == (m_mode == 2), "R11 model lock", lock_o, m_mode == 2);
    chk(hold_o == (m_mode == 3), "R11 model hold", hold_o, m_mode == 3);
    chk(mode_evt_o == m_evt, "R12 model evt", mode_evt_o, m_evt);
  endtask

  task automatic step();
    model_next();
    @(posedge clk); #1;
    model_commit();
    cmp_model();
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_mode = 0; m_sel = 0; m_syn = 0; m_evt = 0;
    for (int i = 0; i < NREF; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic set_pri(int p0, int p1, int p2);
    pri_i = {4'(p2), 4'(p1), 4'(p0)};
  endtask

  initial begin
    qual_i = 0; lock_i = 0; tick_i = 0; man_en_i = 0; man_mode_i = 0; man_ref_i = 0;
    rev_en_i = 0; wtr_i = 0; set_pri(5, 3, 3);
    do_reset();
    // R1 reset state
    chk(mode_o == 0, "R1 mode", mode_o, 0);
    chk(sel_ref_o == 0, "R1 sel", sel_ref_o, 0);
    chk(!lock_o && !hold_o && !mode_evt_o, "R1 indicators", {lock_o, hold_o, mode_evt_o}, 0);
    step();
    chk(mode_o == 0, "R2 stays free-run with none qualified", mode_o, 0);
    // R2 + R7: ref2 beats ref0
    qual_i = 3'b101; step();
    chk(mode_o == 1 && sel_ref_o == 2, "R2 acquire on ref2", {mode_o, sel_ref_o}, {2'd1, 2'd2});
    chk(mode_evt_o == 1, "R12 pulse on entry", mode_evt_o, 1);
    step();
    chk(mode_evt_o == 0, "R12 pulse one cycle", mode_evt_o, 0);
    // R8: ref1 ties ref2 but wins on index; no revertive -> stay
    qual_i = 3'b111; step();
    chk(sel_ref_o == 2, "R8 no revert without enable", sel_ref_o, 2);
    lock_i = 1; step();
    chk(mode_o == 2 && lock_o, "R3 normal on lock", mode_o, 2);
    chk(lock_o && !hold_o, "R11 lock indicator", {lock_o, hold_o}, 2'b10);
    rev_en_i = 3'b010; step();
    chk(mode_o == 1 && sel_ref_o == 1, "R8 revert to ref1 (R7 tie)", sel_ref_o, 1);
    step();
    chk(mode_o == 2, "R3 relock", mode_o, 2);
    // R4: fail ref1, ref2 available
    rev_en_i = 0; qual_i = 3'b101; step();
    chk(mode_o == 1 && sel_ref_o == 2, "R4 switch to ref2", sel_ref_o, 2);
    step();
    chk(mode_o == 2, "R3 lock on ref2", mode_o, 2);
    // R5: all fail -> holdover; R9 load wait time
    wtr_i = 3; qual_i = 0; step();
    chk(mode_o == 3 && hold_o && !lock_o, "R5 holdover", mode_o, 3);
    qual_i = 3'b001; step(); step();
    chk(mode_o == 3, "R9 waiting before restore", mode_o, 3);
    tick_i = 1; step(); step(); step();
    tick_i = 0;
    chk(mode_o == 3, "R9 still waiting after ticks", mode_o, 3);
    step();
    chk(mode_o == 1 && sel_ref_o == 0, "R6 R9 restore to ref0", {mode_o, sel_ref_o}, {2'd1, 2'd0});
    // R10 manual override
    man_en_i = 1; man_mode_i = 3; man_ref_i = 2; step();
    chk(mode_o == 3 && sel_ref_o == 2, "R10 forced holdover ref2", {mode_o, sel_ref_o}, {2'd3, 2'd2});
    man_ref_i = 3; man_mode_i = 1; step();
    chk(sel_ref_o == 2 && mode_o == 1, "R10 out-of-range ref ignored", sel_ref_o, 2);
    step();
    chk(mode_o == 1, "R10 lock ignored in manual", mode_o, 1);
    man_en_i = 0;
    // R5 never-synced path
    lock_i = 0; wtr_i = 0; qual_i = 0;
    do_reset();
    qual_i = 3'b001; step();
    chk(mode_o == 1, "R2 acquire after reset", mode_o, 1);
    qual_i = 0; step();
    chk(mode_o == 0 && !hold_o, "R5 back to free-run unsynced", mode_o, 0);
    // random phase
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 7) == 0) qual_i[$urandom_range(0, NREF-1)] ^= 1'b1;
      if ($urandom_range(0, 31) == 0) pri_i = PRI_W*NREF'($urandom);
      if ($urandom_range(0, 15) == 0) rev_en_i = NREF'($urandom);
      if ($urandom_range(0, 63) == 0) wtr_i = WTR_W'($urandom_range(0, 3));
      lock_i = ($urandom_range(0, 3) == 0);
      tick_i = ($urandom_range(0, 3) == 0);
      man_en_i = ($urandom_range(0, 19) == 0);
      man_mode_i = 2'($urandom);
      man_ref_i = 2'($urandom);
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule